// File: doc/BRIEF.md
# CPU Interrupt Sequencing Controller

This block sits beside the instruction sequencer of an 8-bit CPU core. At every instruction boundary it chooses one of four sequences: a reset entry, a non-maskable interrupt entry, a maskable interrupt entry, or an ordinary opcode fetch. It reports the choice to the core with a one-cycle strobe and a 2-bit code. For every entry sequence it then presents the 16-bit vector address as two byte reads, low byte first, and ends with a one-cycle done pulse. It also raises strobes for the core's flag register: one that sets the interrupt-disable flag and one that clears the decimal flag.

The non-maskable line is edge-captured. The maskable line is gated by the interrupt-disable flag and passes through a one-cycle history register before it counts as pending. A software-break strobe from the core asks for the break vector. In the older (non-CMOS) variant, a pending non-maskable request takes over that vector fetch and is consumed by it. The block also holds the core in one of two halt states when the core asks for them. A stop halt is left only by a reset request. A wait halt is left by a pending non-maskable request or by a high maskable line, whether or not that line is masked.

Top module: `irq_seq_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, `seq_valid_o`, `vec_rd_o`, `vec_done_o`, `set_imask_o` and `clr_dec_o` are 0 and `halt_o` is 0 (running). Pending non-maskable and power-on requests are discarded, so a boundary on quiet lines then selects a fetch.
- R2: A decision is taken at a clock edge where `boundary_i` is high while the block is running and idle. In the following cycle `seq_valid_o` is 1 and `seq_sel_o` holds the choice. The codes are 0 fetch, 1 reset, 2 non-maskable, 3 maskable. A reset request wins over a non-maskable request, which wins over a maskable request.
- R3: A rising edge on `nmi_i` makes a non-maskable request pending, and taking that sequence clears it. A line held high raises no further request until it falls and rises again.
- R4: A high `irq_i` sampled with `irq_mask_i` low at edge t can first be taken by a boundary at edge t+2. A boundary at edge t+1 still selects a fetch. While `irq_mask_i` is 1, the line raises no request.
- R5: The vector is 0xFFFC for reset, 0xFFFA for the non-maskable request, and 0xFFFE for the maskable request and for a software break.
- R6: An entry sequence drives `vec_rd_o` high for two consecutive cycles, starting in the cycle after the decision. `vec_addr_o` holds the vector in the first of these cycles and the vector plus one in the second. `vec_done_o` pulses in the cycle after that. A fetch decision starts no vector read.
- R7: A `brk_vec_i` strobe starts a vector read without a sequence decision. With `cmos_i` = 0 and a non-maskable request pending, the read uses 0xFFFA and clears that request. With `cmos_i` = 1 it always uses 0xFFFE and the request stays pending.
- R8: `set_imask_o` pulses in the first vector-read cycle of a maskable entry and of a software break. `clr_dec_o` pulses in that cycle for every vector read when `cmos_i` = 1, and never when `cmos_i` = 0.
- R9: A `stp_req_i` strobe sets `halt_o` to 2. While it is stopped, boundaries, break strobes and interrupt lines are ignored. A reset request (reset line high or power-on pending) returns `halt_o` to 0 and selects a reset sequence.
- R10: A `wai_req_i` strobe sets `halt_o` to 1. Boundaries are ignored while waiting. A pending non-maskable request or a high `irq_i` (masked or not) returns `halt_o` to 0 and makes a decision at once. A masked line selects a fetch and an unmasked line selects the maskable entry.
- R11: A `pwr_on_i` pulse leaves a power-on request pending until a reset sequence is selected. `rst_line_i` requests reset for as long as it is high.
- R12: `boundary_i` and `brk_vec_i` are ignored while the two vector-read cycles are in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller |
| rst_line_i | input | 1 | Core reset line, level sensitive |
| pwr_on_i | input | 1 | Power-on pulse |
| nmi_i | input | 1 | Non-maskable interrupt line, edge sensitive |
| irq_i | input | 1 | Maskable interrupt line, level sensitive |
| irq_mask_i | input | 1 | Current interrupt-disable flag of the core |
| boundary_i | input | 1 | Instruction boundary strobe |
| brk_vec_i | input | 1 | Software break asks for its vector |
| cmos_i | input | 1 | 1 selects the CMOS variant behaviour |
| wai_req_i | input | 1 | Wait-for-interrupt request strobe |
| stp_req_i | input | 1 | Stop request strobe |
| seq_valid_o | output | 1 | Decision strobe |
| seq_sel_o | output | 2 | Chosen sequence code |
| vec_rd_o | output | 1 | Vector byte read active |
| vec_addr_o | output | 16 | Vector byte address |
| vec_done_o | output | 1 | Vector read finished |
| set_imask_o | output | 1 | Set interrupt-disable flag strobe |
| clr_dec_o | output | 1 | Clear decimal flag strobe |
| halt_o | output | 2 | 0 running, 1 waiting, 2 stopped |

## Verification
The bench builds the block with its default parameters: a 16-bit vector address with the three vectors at the top of the address space. With only three request sources and one mode bit, the bench sweeps all eight combinations of reset, non-maskable and maskable requests in both variants. For each one it checks the chosen code, both vector byte addresses computed as vector and vector plus one, and both flag strobes. Directed runs then cover the cycle-exact history delay, break takeover in each variant, both halt states with each wake source, and boundaries that arrive during a vector read.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [1:0] {
    SEQ_FETCH = 2'd0,
    SEQ_RESET = 2'd1,
    SEQ_NMI   = 2'd2,
    SEQ_IRQ   = 2'd3
  } seq_e;

  typedef enum logic [1:0] {
    HALT_RUN  = 2'd0,
    HALT_WAIT = 2'd1,
    HALT_STOP = 2'd2
  } halt_e;

  typedef enum logic [1:0] {
    VP_IDLE = 2'd0,
    VP_LO   = 2'd1,
    VP_HI   = 2'd2
  } vphase_e;
endpackage

// File: rtl/isc_req_capture.sv
module isc_req_capture (
  input  logic clk,
  input  logic rst,
  input  logic nmi_i,
  input  logic irq_i,
  input  logic irq_mask_i,
  input  logic pwr_on_i,
  input  logic rst_line_i,
  input  logic nmi_clr_i,
  input  logic pwr_clr_i,
  output logic nmi_pend_o,
  output logic irq_pend_o,
  output logic rst_req_o
);
  logic nmi_q;
  logic irq_hist;
  logic pwr_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q      <= nmi_i;
      nmi_pend_o <= 1'b0;
      irq_hist   <= 1'b0;
      irq_pend_o <= 1'b0;
      pwr_pend   <= 1'b0;
    end else begin
      nmi_q      <= nmi_i;
      nmi_pend_o <= (nmi_pend_o & ~nmi_clr_i) | (nmi_i & ~nmi_q);
      irq_hist   <= irq_i & ~irq_mask_i;
      irq_pend_o <= irq_hist;
      pwr_pend   <= (pwr_pend & ~pwr_clr_i) | pwr_on_i;
    end
  end

  always_comb rst_req_o = rst_line_i | pwr_pend;

  AST_NMI_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_pend_o) |-> ($past(nmi_i) && !$past(nmi_q))); // R3

  AST_IRQ_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq_pend_o |-> $past(irq_i && !irq_mask_i, 2)); // R4
endmodule

// File: rtl/isc_halt_ctrl.sv
module isc_halt_ctrl
  import isc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  stp_i,
  input  logic  wai_i,
  input  logic  accept_i,
  input  logic  wake_stop_i,
  input  logic  wake_wait_i,
  output halt_e state_o,
  output logic  wake_o
);
  always_comb
    wake_o = ((state_o == HALT_STOP) && wake_stop_i) ||
             ((state_o == HALT_WAIT) && wake_wait_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= HALT_RUN;
    end else begin
      case (state_o)
        HALT_RUN: begin
          if (accept_i && stp_i)      state_o <= HALT_STOP;
          else if (accept_i && wai_i) state_o <= HALT_WAIT;
        end
        HALT_WAIT: if (wake_wait_i) state_o <= HALT_RUN;
        HALT_STOP: if (wake_stop_i) state_o <= HALT_RUN;
        default:   state_o <= HALT_RUN;
      endcase
    end
  end

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_o == HALT_STOP && !wake_stop_i) |=> (state_o == HALT_STOP)); // R9

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_o == HALT_WAIT && !wake_wait_i) |=> (state_o == HALT_WAIT)); // R10
endmodule

// File: rtl/isc_vec_fetch.sv
module isc_vec_fetch
  import isc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  vphase_e phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= VP_IDLE;
      addr_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (phase)
        VP_IDLE: if (start_i) begin
          phase  <= VP_LO;
          addr_o <= base_i;
        end
        VP_LO: begin
          phase  <= VP_HI;
          addr_o <= addr_o + ONE;
        end
        VP_HI: begin
          phase  <= VP_IDLE;
          done_o <= 1'b1;
        end
        default: phase <= VP_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_o   = (phase != VP_IDLE);
    busy_o = (phase != VP_IDLE);
  end

  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (rst)
    (phase == VP_HI) |-> ($past(phase) == VP_LO && addr_o == $past(addr_o) + ONE)); // R6

  AST_DONE_AFTER_HI: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(phase) == VP_HI && !rd_o)); // R6
endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import isc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] VEC_RESET = 16'hFFFC,
  parameter logic [ADDR_W-1:0] VEC_NMI   = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_IRQ   = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_line_i,
  input  logic              pwr_on_i,
  input  logic              nmi_i,
  input  logic              irq_i,
  input  logic              irq_mask_i,
  input  logic              boundary_i,
  input  logic              brk_vec_i,
  input  logic              cmos_i,
  input  logic              wai_req_i,
  input  logic              stp_req_i,
  output logic              seq_valid_o,
  output logic [1:0]        seq_sel_o,
  output logic              vec_rd_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              vec_done_o,
  output logic              set_imask_o,
  output logic              clr_dec_o,
  output logic [1:0]        halt_o
);
  logic nmi_pend, irq_pend, rst_req;
  logic nmi_clr, pwr_clr;
  logic busy, wake;
  halt_e halt_st;
  logic running, decide, irq_now, brk_go, brk_take, vec_start;
  seq_e sel_c;
  logic [ADDR_W-1:0] vec_base;

  isc_req_capture u_req (
    .clk(clk), .rst(rst), .nmi_i(nmi_i), .irq_i(irq_i), .irq_mask_i(irq_mask_i),
    .pwr_on_i(pwr_on_i), .rst_line_i(rst_line_i), .nmi_clr_i(nmi_clr),
    .pwr_clr_i(pwr_clr), .nmi_pend_o(nmi_pend), .irq_pend_o(irq_pend),
    .rst_req_o(rst_req)
  );

  isc_halt_ctrl u_halt (
    .clk(clk), .rst(rst), .stp_i(stp_req_i), .wai_i(wai_req_i),
    .accept_i(!busy), .wake_stop_i(rst_req),
    .wake_wait_i(nmi_pend || irq_i), .state_o(halt_st), .wake_o(wake)
  );

  always_comb begin
    running  = (halt_st == HALT_RUN);
    decide   = (running && boundary_i && !busy) || wake;
    irq_now  = irq_pend || ((halt_st == HALT_WAIT) && irq_i && !irq_mask_i);
    if (rst_req)       sel_c = SEQ_RESET;
    else if (nmi_pend) sel_c = SEQ_NMI;
    else if (irq_now)  sel_c = SEQ_IRQ;
    else               sel_c = SEQ_FETCH;
    brk_go   = running && !busy && brk_vec_i && !decide;
    brk_take = brk_go && !cmos_i && nmi_pend;
    nmi_clr  = (decide && sel_c == SEQ_NMI) || brk_take;
    pwr_clr  = decide && sel_c == SEQ_RESET;
    vec_start = (decide && sel_c != SEQ_FETCH) || brk_go;
    if (decide) begin
      case (sel_c)
        SEQ_RESET: vec_base = VEC_RESET;
        SEQ_NMI:   vec_base = VEC_NMI;
        default:   vec_base = VEC_IRQ;
      endcase
    end else begin
      vec_base = brk_take ? VEC_NMI : VEC_IRQ;
    end
  end

  isc_vec_fetch #(.ADDR_W(ADDR_W)) u_vec (
    .clk(clk), .rst(rst), .start_i(vec_start), .base_i(vec_base),
    .rd_o(vec_rd_o), .addr_o(vec_addr_o), .done_o(vec_done_o), .busy_o(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_valid_o <= 1'b0;
      seq_sel_o   <= SEQ_FETCH;
      set_imask_o <= 1'b0;
      clr_dec_o   <= 1'b0;
    end else begin
      seq_valid_o <= decide;
      if (decide) seq_sel_o <= sel_c;
      set_imask_o <= (decide && sel_c == SEQ_IRQ) || brk_go;
      clr_dec_o   <= cmos_i && vec_start;
    end
  end

  always_comb halt_o = halt_st;

  AST_NMI_BELOW_RESET: assert property (@(posedge clk) disable iff (rst)
    (seq_valid_o && seq_sel_o == SEQ_NMI) |-> $past(!rst_req)); // R2

  AST_STOP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (halt_st == HALT_STOP && !rst_req) |=> !seq_valid_o); // R9

  AST_IMASK_WITH_READ: assert property (@(posedge clk) disable iff (rst)
    set_imask_o |-> vec_rd_o); // R8

  AST_NO_DECIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && running) |=> !seq_valid_o); // R12
endmodule

// File: tb/irq_seq_ctrl_tb_top.sv
module irq_seq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rst_line_i = 0, pwr_on_i = 0, nmi_i = 0, irq_i = 0, irq_mask_i = 0;
  logic boundary_i = 0, brk_vec_i = 0, cmos_i = 0, wai_req_i = 0, stp_req_i = 0;
  logic seq_valid_o, vec_rd_o, vec_done_o, set_imask_o, clr_dec_o;
  logic [1:0] seq_sel_o, halt_o;
  logic [15:0] vec_addr_o;

  localparam logic [15:0] V_RST = 16'hFFFC, V_NMI = 16'hFFFA, V_IRQ = 16'hFFFE;

  int checks = 0, errors = 0;
  int n_dec = 0, n_rd = 0, n_done = 0;
  logic [1:0] sel_log [0:7];
  logic [15:0] lo_a = 0, hi_a = 0;
  logic seen_si = 0, seen_cd = 0;

  always #4 clk = ~clk;

  irq_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .rst_line_i(rst_line_i), .pwr_on_i(pwr_on_i),
    .nmi_i(nmi_i), .irq_i(irq_i), .irq_mask_i(irq_mask_i), .boundary_i(boundary_i),
    .brk_vec_i(brk_vec_i), .cmos_i(cmos_i), .wai_req_i(wai_req_i), .stp_req_i(stp_req_i),
    .seq_valid_o(seq_valid_o), .seq_sel_o(seq_sel_o), .vec_rd_o(vec_rd_o),
    .vec_addr_o(vec_addr_o), .vec_done_o(vec_done_o), .set_imask_o(set_imask_o),
    .clr_dec_o(clr_dec_o), .halt_o(halt_o)
  );

  always @(negedge clk) begin
    if (seq_valid_o) begin
      sel_log[n_dec[2:0]] = seq_sel_o;
      n_dec = n_dec + 1;
    end
    if (vec_rd_o) begin
      if (n_rd == 0) lo_a = vec_addr_o; else hi_a = vec_addr_o;
      n_rd = n_rd + 1;
    end
    if (vec_done_o) n_done = n_done + 1;
    if (set_imask_o) seen_si = 1;
    if (clr_dec_o) seen_cd = 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_mon();
    n_dec = 0; n_rd = 0; n_done = 0; seen_si = 0; seen_cd = 0;
    lo_a = 0; hi_a = 0;
  endtask

  task automatic do_reset();
    rst = 1; tick(2); rst = 0; tick(1);
    clr_mon();
  endtask

  task automatic bound_raw();
    boundary_i = 1; tick(1); boundary_i = 0;
  endtask

  task automatic bound();
    bound_raw(); tick(4);
  endtask

  task automatic nmi_pulse();
    nmi_i = 1; tick(1); nmi_i = 0; tick(1);
  endtask

  function automatic logic [15:0] vec_of(input int s);
    return (s == 1) ? V_RST : (s == 2) ? V_NMI : V_IRQ;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 0; tick(1);
    // R1 reset state
    chk("R1 valid", seq_valid_o, 0);
    chk("R1 rd", vec_rd_o, 0);
    chk("R1 halt", halt_o, 0);
    chk("R1 done", vec_done_o, 0);
    nmi_pulse(); pwr_on_i = 1; tick(1); pwr_on_i = 0; tick(1);
    do_reset(); bound();
    chk("R1 pending cleared", sel_log[0], 0);

    // R2 R5 R6 R8: sweep of request combinations in both variants
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 8; c++) begin
        int es;
        do_reset();
        cmos_i = m[0];
        rst_line_i = c[2];
        if (c[1]) nmi_pulse();
        irq_i = c[0]; irq_mask_i = 0;
        tick(3); clr_mon();
        bound();
        es = c[2] ? 1 : c[1] ? 2 : c[0] ? 3 : 0;
        chk("R2 decisions", n_dec, 1);
        chk("R2 priority", sel_log[0], es);
        if (es != 0) begin
          chk("R5 vector lo", lo_a, vec_of(es));
          chk("R6 vector hi", hi_a, vec_of(es) + 16'd1);
          chk("R6 done", n_done, 1);
          chk("R8 imask", seen_si, (es == 3) ? 1 : 0);
          chk("R8 decimal", seen_cd, m);
        end else begin
          chk("R6 no read on fetch", n_rd, 0);
        end
        rst_line_i = 0; irq_i = 0; tick(2);
      end
    end
    cmos_i = 0;

    // R3 edge capture
    do_reset();
    nmi_i = 1; tick(2);
    bound(); bound();
    chk("R3 taken", sel_log[0], 2);
    chk("R3 no retrigger", sel_log[1], 0);
    nmi_i = 0; tick(1); nmi_i = 1; tick(1); clr_mon(); bound();
    chk("R3 new edge", sel_log[0], 2);
    nmi_i = 0;

    // R4 history timing and masking
    do_reset();
    irq_i = 1; tick(1);
    bound_raw(); bound_raw(); tick(4);
    chk("R4 t+1 fetch", sel_log[0], 0);
    chk("R4 t+2 irq", sel_log[1], 3);
    irq_i = 0; tick(3);
    do_reset();
    irq_mask_i = 1; irq_i = 1; tick(3); bound();
    chk("R4 masked", sel_log[0], 0);
    irq_i = 0; irq_mask_i = 0; tick(2);

    // R7 break vector selection
    do_reset(); cmos_i = 0; nmi_pulse(); clr_mon();
    brk_vec_i = 1; tick(1); brk_vec_i = 0; tick(4);
    chk("R7 nmos takeover", lo_a, V_NMI);
    chk("R8 brk imask", seen_si, 1);
    chk("R7 no decision", n_dec, 0);
    bound();
    chk("R7 nmi consumed", sel_log[0], 0);
    do_reset(); cmos_i = 1; nmi_pulse(); clr_mon();
    brk_vec_i = 1; tick(1); brk_vec_i = 0; tick(4);
    chk("R7 cmos vector", lo_a, V_IRQ);
    bound();
    chk("R7 cmos nmi kept", sel_log[0], 2);
    cmos_i = 0;

    // R9 stop halt
    do_reset();
    stp_req_i = 1; tick(1); stp_req_i = 0;
    chk("R9 stopped", halt_o, 2);
    nmi_pulse(); irq_i = 1; bound();
    brk_vec_i = 1; tick(1); brk_vec_i = 0; tick(3);
    chk("R9 ignored", n_dec + n_rd, 0);
    irq_i = 0; rst_line_i = 1; tick(1); rst_line_i = 0; tick(4);
    chk("R9 wake reset", sel_log[0], 1);
    chk("R9 running", halt_o, 0);

    // R10 wait halt
    do_reset();
    wai_req_i = 1; tick(1); wai_req_i = 0;
    chk("R10 waiting", halt_o, 1);
    bound();
    chk("R10 boundary ignored", n_dec, 0);
    irq_mask_i = 1; irq_i = 1; tick(3);
    chk("R10 masked wake fetch", sel_log[0], 0);
    chk("R10 running", halt_o, 0);
    irq_i = 0; irq_mask_i = 0; tick(2);
    do_reset();
    wai_req_i = 1; tick(1); wai_req_i = 0;
    irq_i = 1; tick(4);
    chk("R10 unmasked wake irq", sel_log[0], 3);
    irq_i = 0; tick(2);
    do_reset();
    wai_req_i = 1; tick(1); wai_req_i = 0;
    nmi_pulse(); tick(3);
    chk("R10 nmi wake", sel_log[0], 2);

    // R11 power-on request
    do_reset();
    pwr_on_i = 1; tick(1); pwr_on_i = 0; tick(3);
    bound(); bound();
    chk("R11 power-on reset", sel_log[0], 1);
    chk("R11 power-on cleared", sel_log[1], 0);
    clr_mon(); rst_line_i = 1; bound(); bound(); rst_line_i = 0;
    chk("R11 reset level", sel_log[1], 1);

    // R12 busy window
    do_reset();
    rst_line_i = 1; bound_raw(); rst_line_i = 0;
    boundary_i = 1; brk_vec_i = 1; tick(1); boundary_i = 0; brk_vec_i = 0; tick(4);
    chk("R12 one decision", n_dec, 1);
    chk("R12 two reads", n_rd, 2);
    chk("R12 one done", n_done, 1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule